// File: doc/BRIEF.md
# Memory Access Strobe Sequencer

This block times a single external memory access in functional-clock cycles. It drives four active-low control strobes: chip-select, address-valid, output-enable and write-enable. A one-cycle pulse marks the moment to capture data, and a second one-cycle pulse marks the end of the access. A start pulse opens the access and a direction flag picks read or write. The programmed times then set when each strobe falls and rises, when capture fires and when the access ends.

Every strobe has its own on-count and off-count. Reads and writes each have their own access time and cycle time. A granularity bit doubles every programmed value, so the 5-bit fields reach 62 cycles. Each strobe can also be moved half a functional-clock period later. This gives setup and hold margin when the external memory clock runs at the full functional rate. The timing fields are static configuration: they must not change while an access runs, and every off-count must not exceed the cycle time of that direction.

Top module: `acc_strobe_seq`

## Requirements
- R1: After reset and whenever no access runs, all four strobes are high and both capture and done are low.
- R2: The effective value of every timing field is the field itself when the granularity bit is 0, and twice the field when it is 1. The granularity bit and the direction flag are latched with the accepted start.
- R3: The counter is 0 in the cycle after the accepted start edge and then advances by one each cycle. The outputs seen after rising edge k+1 (counting the start edge as edge 0) reflect count k. Chip-select and address-valid are low for counts from their on-value up to, but not including, their off-value, on reads and on writes.
- R4: Output-enable follows its window only on reads and write-enable only on writes; the other one stays high.
- R5: When a strobe's half-cycle enable is set, both of its edges happen on the falling clock edge half a period after they would happen otherwise.
- R6: Capture is high for exactly one cycle, at the count equal to the read access time on reads or the write access time on writes.
- R7: Done is high for exactly one cycle, at the count equal to the read or write cycle time, and the access ends at that edge.
- R8: A start while an access runs is ignored. A start is accepted at any rising edge where no access runs, including the edge that closes the done cycle.
- R9: Strobe fields are packed arrays indexed 0 = chip-select, 1 = address-valid, 2 = output-enable, 3 = write-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an access (accepted only when idle) |
| is_write | input | 1 | 1 = write access, 0 = read access |
| gran | input | 1 | 1 = all timing fields count in units of two cycles |
| stb_on | input | 4x5 | Per-strobe assertion count, index per R9 |
| stb_off | input | 4x5 | Per-strobe deassertion count, index per R9 |
| stb_half | input | 4 | Per-strobe half-period delay enable, index per R9 |
| rd_access | input | 5 | Read data-capture count |
| wr_access | input | 5 | Write data-capture count |
| rd_cycle | input | 5 | Read access length (count of the last cycle) |
| wr_cycle | input | 5 | Write access length (count of the last cycle) |
| cs_n | output | 1 | Chip-select, active low |
| adv_n | output | 1 | Address-valid, active low |
| oe_n | output | 1 | Output-enable, active low |
| we_n | output | 1 | Write-enable, active low |
| capture | output | 1 | One-cycle data-capture pulse |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench runs reads and writes with different access and cycle times for the two directions. This shows whether the direction flag picks the right pair and gates output-enable against write-enable. The same windows are run with the granularity bit clear and set, which separates a correctly doubled count from an unscaled one. Half-cycle delay is tried on all strobes at once and on a mixed subset. Each strobe is sampled after both clock edges, so a shift on the wrong edge or on the wrong strobe is visible. Boundary runs use zero on-counts and capture equal to the cycle time, near-maximum doubled values, back-to-back starts on the done edge, and a stray start in the middle of an access.

// File: rtl/acc_seq_pkg.sv
`timescale 1ns/1ps
package acc_seq_pkg;
   localparam int unsigned STB_COUNT = 4;

   typedef enum logic [1:0] {
      STB_CS  = 2'd0,
      STB_ADV = 2'd1,
      STB_OE  = 2'd2,
      STB_WE  = 2'd3
   } stb_idx_e;

   // which accesses may drive a given strobe
   typedef enum logic [1:0] {
      QUAL_BOTH  = 2'd0,
      QUAL_READ  = 2'd1,
      QUAL_WRITE = 2'd2
   } stb_qual_e;

   function automatic stb_qual_e qual_of(input int unsigned idx);
      if (idx == STB_OE) return QUAL_READ;
      if (idx == STB_WE) return QUAL_WRITE;
      return QUAL_BOTH;
   endfunction
endpackage

// File: rtl/acc_seq_scale.sv
`timescale 1ns/1ps
// Converts a raw timing field to cycles, doubling it under coarse granularity.
module acc_seq_scale #(
   parameter int unsigned TW = 5
) (
   input  logic [TW-1:0] raw,
   input  logic          dbl,
   output logic [TW:0]   eff
);
   always_comb begin
      if (dbl) eff = {raw, 1'b0};
      else     eff = {1'b0, raw};
   end
endmodule

// File: rtl/acc_seq_timer.sv
`timescale 1ns/1ps
// Access cycle counter: accepts a start when idle, counts up to the cycle
// time of the latched direction, and emits capture and done pulses.
module acc_seq_timer #(
   parameter int unsigned CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_write,
   input  logic          gran,
   input  logic [CW-1:0] rd_acc_eff,
   input  logic [CW-1:0] wr_acc_eff,
   input  logic [CW-1:0] rd_cyc_eff,
   input  logic [CW-1:0] wr_cyc_eff,
   output logic          busy,
   output logic [CW-1:0] cnt,
   output logic          wr_dir,
   output logic          gran_dir,
   output logic          capture,
   output logic          done
);
   logic          busy_q, wr_q, gran_q, cap_q, done_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] acc_sel, cyc_sel;
   logic          at_end;

   assign acc_sel = wr_q ? wr_acc_eff : rd_acc_eff;
   assign cyc_sel = wr_q ? wr_cyc_eff : rd_cyc_eff;
   assign at_end  = busy_q && (cnt_q == cyc_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         wr_q   <= 1'b0;
         gran_q <= 1'b0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            wr_q   <= is_write;
            gran_q <= gran;
         end
      end else if (at_end) begin
         busy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         cap_q  <= busy_q && (cnt_q == acc_sel);
         done_q <= at_end;
      end
   end

   assign busy     = busy_q;
   assign cnt      = cnt_q;
   assign wr_dir   = wr_q;
   assign gran_dir = gran_q;
   assign capture  = cap_q;
   assign done     = done_q;
endmodule

// File: rtl/acc_seq_strobe.sv
`timescale 1ns/1ps
// One control strobe: window compare, rising-edge register, and an optional
// falling-edge copy selected per strobe to shift both edges by half a period.
module acc_seq_strobe #(
   parameter int unsigned CW           = 6,
   parameter bit          HALF_SUPPORT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   input  logic          allow,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] on_eff,
   input  logic [CW-1:0] off_eff,
   input  logic          half_en,
   output logic          strobe_n
);
   logic in_window;
   logic pos_n_q;

   assign in_window = busy && allow && (cnt >= on_eff) && (cnt < off_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_n_q <= 1'b1;
      else        pos_n_q <= ~in_window;
   end

   generate
      if (HALF_SUPPORT) begin : g_half
         logic neg_n_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) neg_n_q <= 1'b1;
            else        neg_n_q <= pos_n_q;
         end
         assign strobe_n = half_en ? neg_n_q : pos_n_q;
      end else begin : g_full
         assign strobe_n = pos_n_q;
      end
   endgenerate
endmodule

// File: rtl/acc_strobe_seq.sv
`timescale 1ns/1ps
module acc_strobe_seq
   import acc_seq_pkg::*;
#(
   parameter int unsigned TW           = 5,
   parameter bit          HALF_SUPPORT = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic                           is_write,
   input  logic                           gran,
   input  logic [STB_COUNT-1:0][TW-1:0]   stb_on,
   input  logic [STB_COUNT-1:0][TW-1:0]   stb_off,
   input  logic [STB_COUNT-1:0]           stb_half,
   input  logic [TW-1:0]                  rd_access,
   input  logic [TW-1:0]                  wr_access,
   input  logic [TW-1:0]                  rd_cycle,
   input  logic [TW-1:0]                  wr_cycle,
   output logic                           cs_n,
   output logic                           adv_n,
   output logic                           oe_n,
   output logic                           we_n,
   output logic                           capture,
   output logic                           done
);
   localparam int unsigned CW = TW + 1;

   generate
      if (TW < 2 || TW > 10) begin : g_bad_tw
         $error("acc_strobe_seq: TW must lie between 2 and 10");
      end
   endgenerate

   logic          busy_w, wr_w, gran_w;
   logic [CW-1:0] cnt_w;
   logic [CW-1:0] rd_acc_eff, wr_acc_eff, rd_cyc_eff, wr_cyc_eff;
   logic [STB_COUNT-1:0][CW-1:0] on_eff, off_eff;
   logic [STB_COUNT-1:0]         strobe_n;

   // granularity of the access/cycle fields follows the latched bit while busy
   acc_seq_scale #(.TW(TW)) i_sc_rda (.raw(rd_access), .dbl(gran_w), .eff(rd_acc_eff));
   acc_seq_scale #(.TW(TW)) i_sc_wra (.raw(wr_access), .dbl(gran_w), .eff(wr_acc_eff));
   acc_seq_scale #(.TW(TW)) i_sc_rdc (.raw(rd_cycle),  .dbl(gran_w), .eff(rd_cyc_eff));
   acc_seq_scale #(.TW(TW)) i_sc_wrc (.raw(wr_cycle),  .dbl(gran_w), .eff(wr_cyc_eff));

   acc_seq_timer #(.CW(CW)) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .is_write   (is_write),
      .gran       (gran),
      .rd_acc_eff (rd_acc_eff),
      .wr_acc_eff (wr_acc_eff),
      .rd_cyc_eff (rd_cyc_eff),
      .wr_cyc_eff (wr_cyc_eff),
      .busy       (busy_w),
      .cnt        (cnt_w),
      .wr_dir     (wr_w),
      .gran_dir   (gran_w),
      .capture    (capture),
      .done       (done)
   );

   generate
      for (genvar gi = 0; gi < STB_COUNT; gi++) begin : g_stb
         logic allow;
         if (qual_of(gi) == QUAL_READ) begin : g_rd
            assign allow = ~wr_w;
         end else if (qual_of(gi) == QUAL_WRITE) begin : g_wr
            assign allow = wr_w;
         end else begin : g_any
            assign allow = 1'b1;
         end

         acc_seq_scale #(.TW(TW)) i_sc_on  (.raw(stb_on[gi]),  .dbl(gran_w), .eff(on_eff[gi]));
         acc_seq_scale #(.TW(TW)) i_sc_off (.raw(stb_off[gi]), .dbl(gran_w), .eff(off_eff[gi]));

         acc_seq_strobe #(.CW(CW), .HALF_SUPPORT(HALF_SUPPORT)) i_strobe (
            .clk      (clk),
            .rst_n    (rst_n),
            .busy     (busy_w),
            .allow    (allow),
            .cnt      (cnt_w),
            .on_eff   (on_eff[gi]),
            .off_eff  (off_eff[gi]),
            .half_en  (stb_half[gi]),
            .strobe_n (strobe_n[gi])
         );
      end
   endgenerate

   assign cs_n  = strobe_n[STB_CS];
   assign adv_n = strobe_n[STB_ADV];
   assign oe_n  = strobe_n[STB_OE];
   assign we_n  = strobe_n[STB_WE];
endmodule

// File: rtl/acc_strobe_seq_chk.sv
`timescale 1ns/1ps
module acc_strobe_seq_chk #(
   parameter int unsigned CW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic [CW-1:0] cnt,
   input logic          cs_n,
   input logic          adv_n,
   input logic          oe_n,
   input logic          we_n,
   input logic          capture,
   input logic          done
);
   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> (cs_n && adv_n && oe_n && we_n));

   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (cnt == CW'($past(cnt) + 1'b1)));

   assert_oe_we_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n));

   assert_capture_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> !capture);

   assert_capture_in_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> $past(busy));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && cnt == '0) |=> !(busy && cnt == '0));
endmodule

bind acc_strobe_seq acc_strobe_seq_chk #(.CW(TW + 1)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy_w),
   .cnt     (cnt_w),
   .cs_n    (cs_n),
   .adv_n   (adv_n),
   .oe_n    (oe_n),
   .we_n    (we_n),
   .capture (capture),
   .done    (done)
);

// File: tb/test_acc_strobe_seq.sv
`timescale 1ns/1ps
module test_acc_strobe_seq;
   logic                clk = 1'b0;
   logic                rst_n;
   logic                start, is_write, gran;
   logic [3:0][4:0]     stb_on, stb_off;
   logic [3:0]          stb_half;
   logic [4:0]          rd_access, wr_access, rd_cycle, wr_cycle;
   logic                cs_n, adv_n, oe_n, we_n, capture, done;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   typedef struct packed {
      logic            w;
      logic [3:0][5:0] on;
      logic [3:0][5:0] off;
      logic [3:0]      hf;
      logic [5:0]      acc;
      logic [5:0]      cyc;
   } exp_t;

   exp_t sb[$];

   always #2 clk = ~clk;   // 250 MHz

   acc_strobe_seq i_acc_strobe_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write), .gran(gran),
      .stb_on(stb_on), .stb_off(stb_off), .stb_half(stb_half),
      .rd_access(rd_access), .wr_access(wr_access),
      .rd_cycle(rd_cycle), .wr_cycle(wr_cycle),
      .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n),
      .capture(capture), .done(done)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [3:0][4:0] pk(input int cs, input int adv, input int oe, input int we);
      logic [3:0][4:0] r;
      r[0] = 5'(cs); r[1] = 5'(adv); r[2] = 5'(oe); r[3] = 5'(we);   // R9 order
      return r;
   endfunction

   // check all strobes at half-phase h of an access
   task automatic chk_strobes(input exp_t it, input int h);
      logic [3:0] act;
      act = {we_n, oe_n, adv_n, cs_n};
      for (int i = 0; i < 4; i++) begin
         bit allow, low;
         int lo, hi;
         string req;
         allow = (i == 2) ? !it.w : (i == 3) ? it.w : 1'b1;
         lo = 2 * int'(it.on[i])  + (it.hf[i] ? 1 : 0);
         hi = 2 * int'(it.off[i]) + (it.hf[i] ? 1 : 0);
         low = allow && (h >= lo) && (h < hi);
         req = it.hf[i] ? "R5" : (i < 2) ? "R3" : "R4";
         chk(req, $sformatf("strobe%0d half-phase %0d", i, h), act[i], ~low);
      end
   endtask

   // driver: sets the configuration, starts one access, pushes its expectation
   task automatic run_access(input bit w, input bit g,
                             input logic [3:0][4:0] on, input logic [3:0][4:0] off,
                             input logic [3:0] hf,
                             input int rdacc, input int wracc, input int rdcyc, input int wrcyc,
                             input bit poke);
      exp_t e;
      stb_on = on; stb_off = off; stb_half = hf;
      rd_access = 5'(rdacc); wr_access = 5'(wracc);
      rd_cycle = 5'(rdcyc); wr_cycle = 5'(wrcyc);
      is_write = w; gran = g;
      e.w = w; e.hf = hf;
      for (int i = 0; i < 4; i++) begin
         e.on[i]  = 6'(on[i])  << g;   // R2 doubling
         e.off[i] = 6'(off[i]) << g;
      end
      e.acc = 6'(w ? wracc : rdacc) << g;
      e.cyc = 6'(w ? wrcyc : rdcyc) << g;
      start = 1'b1;
      sb.push_back(e);
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         // R8: stray start in the middle of the access
         repeat (2) @(negedge clk);
         start = 1'b1; is_write = ~w; gran = ~g;
         @(negedge clk);
         start = 1'b0;
      end
      while (done !== 1'b1) @(negedge clk);
   endtask

   // monitor: pops expectations and compares outputs after both clock edges
   initial begin
      forever begin
         exp_t it;
         wait (sb.size() > 0);
         it = sb.pop_front();
         @(posedge clk);   // accepting edge
         for (int k = 0; k <= int'(it.cyc); k++) begin
            @(posedge clk); #1;
            chk_strobes(it, 2 * k);
            chk("R6", $sformatf("capture count %0d", k), capture, k == int'(it.acc));
            chk("R7", $sformatf("done count %0d", k), done, k == int'(it.cyc));
            @(negedge clk); #1;
            chk_strobes(it, 2 * k + 1);
         end
      end
   end

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; is_write = 1'b0; gran = 1'b0;
      stb_on = '0; stb_off = '0; stb_half = '0;
      rd_access = '0; wr_access = '0; rd_cycle = '0; wr_cycle = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "cs_n after reset", cs_n, 1'b1);
      chk("R1", "adv_n after reset", adv_n, 1'b1);
      chk("R1", "oe_n after reset", oe_n, 1'b1);
      chk("R1", "we_n after reset", we_n, 1'b1);
      chk("R1", "capture after reset", capture, 1'b0);
      chk("R1", "done after reset", done, 1'b0);

      // R3/R4/R6/R7 plain read; write fields differ and must not matter
      run_access(1'b0, 1'b0, pk(1,0,2,1), pk(7,2,6,5), 4'b0000, 4, 9, 8, 3, 1'b0);
      // R4 write with its own access and cycle times (back-to-back start, R8)
      run_access(1'b1, 1'b0, pk(0,0,3,2), pk(6,3,5,5), 4'b0000, 2, 3, 20, 7, 1'b0);
      // R2 coarse granularity on a read
      run_access(1'b0, 1'b1, pk(1,0,1,0), pk(4,1,4,4), 4'b0000, 3, 1, 5, 2, 1'b0);
      // R5 all strobes delayed, R8 stray start mid-access
      run_access(1'b0, 1'b0, pk(1,0,2,0), pk(6,2,5,3), 4'b1111, 5, 1, 7, 4, 1'b1);
      // R5 chip-select and write-enable delayed only, capture at count 0
      run_access(1'b1, 1'b0, pk(0,1,0,1), pk(5,3,2,4), 4'b1001, 6, 0, 9, 6, 1'b0);
      // R6/R7 capture on the last count, zero on-times
      run_access(1'b0, 1'b0, pk(0,0,0,0), pk(6,1,6,2), 4'b0000, 6, 2, 6, 9, 1'b0);
      // R2/R5 near-maximum doubled write
      run_access(1'b1, 1'b1, pk(0,0,3,1), pk(31,1,9,30), 4'b0001, 4, 31, 3, 31, 1'b0);

      repeat (4) @(negedge clk);
      wait (sb.size() == 0);
      repeat (2) @(negedge clk);
      chk("R1", "cs_n idle", cs_n, 1'b1);
      chk("R1", "adv_n idle", adv_n, 1'b1);
      chk("R1", "oe_n idle", oe_n, 1'b1);
      chk("R1", "we_n idle", we_n, 1'b1);
      chk("R1", "capture idle", capture, 1'b0);
      chk("R1", "done idle", done, 1'b0);
      summary();
   end
endmodule